// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a down-counting interval timer with a small word-addressed register port. Software places a start value in the reload register. Writing that register also sets the live count at once, even while the timer is running. Software then sets the run, repeat and rate bits in the control register. The count steps down by one on each pulse of the chosen tick-enable input. Two tick inputs are available, a slow one and a fast one. The tick inputs are single-cycle enables that come from elsewhere in the chip.

When the count reaches zero, a sticky level interrupt is raised. The interrupt has no enable bit. It falls only when software writes any value to the clear register. In repeat mode the tick that follows zero restores the reload value. In one-shot mode the count stays at zero until the reload register is written again.

The register port is a plain synchronous interface. A write strobe with an address and data is captured at the rising clock edge. Read data is a combinational function of the address.

Top module: `ctmr_top`

## Requirements
- R1: After reset, the reload value, the count, the control bits and the interrupt output are all zero.
- R2: A write to offset 0x0 stores the reload value and sets the count to the written data in the same edge, whether or not the timer is running. Both values read back on the next cycle, at offsets 0x0 and 0x4.
- R3: While control bit 0 (run) is 0, tick pulses leave the count unchanged.
- R4: Control bit 3 selects the tick source: 0 selects `tick_slow_i` and 1 selects `tick_fast_i`. Pulses on the unselected input leave the count unchanged.
- R5: When control bit 1 (repeat) is 0, the count holds at zero after it expires. Further ticks do not change it.
- R6: A selected tick that takes the count from 1 to 0 sets `irq_o`, visible one cycle after the edge.
- R7: `irq_o` stays high through idle cycles and through writes to other registers. Any write to offset 0xC lowers it on the next cycle.
- R8: When control bit 1 is 1, a selected tick at count 0 reloads the reload value, and counting and expiry repeat.
- R9: Reads of the control register at offset 0x8 return only bits 3, 1 and 0, with all other bits zero. Reads of offset 0xC return zero.
- R10: If an expiry and a write to offset 0xC happen in the same cycle, `irq_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_slow_i | input | 1 | Slow single-cycle tick enable |
| tick_fast_i | input | 1 | Fast single-cycle tick enable |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W (4) | Byte offset of the register |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Sticky level interrupt |

## Verification
The bench builds the timer with its default 32-bit data width and 4-bit address, so the register map and the read-back masking are checked at their full size. Small reload values such as 1, 2 and 3 bring expiry, repeat wrap and the clear/expiry collision within a handful of tick pulses. The tick inputs are driven by hand, so the bench controls exactly which edge carries a tick and can line that edge up with a register write.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  // Register byte offsets (the software-visible map).
  localparam int unsigned OFS_RELOAD = 4'h0;
  localparam int unsigned OFS_COUNT  = 4'h4;
  localparam int unsigned OFS_CTRL   = 4'h8;
  localparam int unsigned OFS_CLEAR  = 4'hC;

  // Control bit positions.
  localparam int unsigned CB_RUN    = 0;
  localparam int unsigned CB_REPEAT = 1;
  localparam int unsigned CB_FAST   = 3;

  typedef struct packed {
    logic fast;
    logic repeat_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/ctmr_rst_sync.sv
module ctmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ctmr_regs.sv
module ctmr_regs
  import ctmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] count_i,
  output logic [DATA_W-1:0] reload_o,
  output ctrl_t             ctrl_o,
  output logic              load_wr_o,
  output logic              clr_wr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFS_CLEAR);

  logic [DATA_W-1:0] reload_q, reload_d;
  ctrl_t             ctrl_q, ctrl_d;
  logic              ctrl_wr;

  assign load_wr_o = wr_en_i && (addr_i == A_RELOAD);
  assign ctrl_wr   = wr_en_i && (addr_i == A_CTRL);
  assign clr_wr_o  = wr_en_i && (addr_i == A_CLEAR);

  always_comb begin
    reload_d = reload_q;
    ctrl_d   = ctrl_q;
    if (load_wr_o) reload_d = wdata_i;
    if (ctrl_wr) begin
      ctrl_d.run       = wdata_i[CB_RUN];
      ctrl_d.repeat_en = wdata_i[CB_REPEAT];
      ctrl_d.fast      = wdata_i[CB_FAST];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      ctrl_q   <= '0;
    end else begin
      if (load_wr_o) reload_q <= reload_d;
      if (ctrl_wr)   ctrl_q   <= ctrl_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_RELOAD: rdata_o = reload_q;
      A_COUNT:  rdata_o = count_i;
      A_CTRL: begin
        rdata_o[CB_RUN]    = ctrl_q.run;
        rdata_o[CB_REPEAT] = ctrl_q.repeat_en;
        rdata_o[CB_FAST]   = ctrl_q.fast;
      end
      A_CLEAR:  rdata_o = '0;
      default:  rdata_o = '0;
    endcase
  end

  assign reload_o = reload_q;
  assign ctrl_o   = ctrl_q;

  AST_CTRL_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ctrl_o.run == $past(wdata_i[CB_RUN]) && ctrl_o.fast == $past(wdata_i[CB_FAST]))); // R9
endmodule

// File: rtl/ctmr_counter.sv
module ctmr_counter
  import ctmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_slow_i,
  input  logic              tick_fast_i,
  input  ctrl_t             ctrl_i,
  input  logic [DATA_W-1:0] reload_i,
  input  logic              load_wr_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              clr_wr_i,
  output logic [DATA_W-1:0] count_o,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] count_q, count_d;
  logic              irq_q, irq_d;
  logic              tick_sel, advance, count_en, irq_en, expire;

  assign tick_sel = ctrl_i.fast ? tick_fast_i : tick_slow_i;
  assign advance  = ctrl_i.run && tick_sel;
  assign expire   = advance && !load_wr_i && (count_q == ONE);
  assign count_en = load_wr_i || advance;
  assign irq_en   = expire || clr_wr_i;

  always_comb begin
    count_d = count_q;
    if (load_wr_i) begin
      count_d = load_data_i;
    end else if (advance) begin
      if (count_q != '0)         count_d = count_q - ONE;
      else if (ctrl_i.repeat_en) count_d = reload_i;
    end
  end

  always_comb begin
    irq_d = irq_q;
    if (clr_wr_i) irq_d = 1'b0;
    if (expire)   irq_d = 1'b1;   // expiry beats a simultaneous clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (count_en) count_q <= count_d;
      if (irq_en)   irq_q   <= irq_d;
    end
  end

  assign count_o = count_q;
  assign irq_o   = irq_q;

  AST_LOAD_SETS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr_i |=> (count_o == $past(load_data_i))); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_i.run && !load_wr_i) |=> $stable(count_o)); // R3
  AST_ONESHOT_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == '0 && !ctrl_i.repeat_en && !load_wr_i) |=> (count_o == '0)); // R5
  AST_EXPIRY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load_wr_i && count_o == ONE) |=> (irq_o && count_o == '0)); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clr_wr_i) |=> irq_o); // R7
  AST_REPEAT_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load_wr_i && count_o == '0 && ctrl_i.repeat_en) |=> (count_o == $past(reload_i))); // R8
endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
  import ctmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_slow_i,
  input  logic              tick_fast_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic              rst_int_n;
  logic [DATA_W-1:0] reload, count;
  ctrl_t             ctrl;
  logic              load_wr, clr_wr;

  ctmr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  ctmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .count_i(count), .reload_o(reload), .ctrl_o(ctrl),
    .load_wr_o(load_wr), .clr_wr_o(clr_wr), .rdata_o(rdata_o)
  );

  ctmr_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .tick_slow_i(tick_slow_i),
    .tick_fast_i(tick_fast_i), .ctrl_i(ctrl), .reload_i(reload),
    .load_wr_i(load_wr), .load_data_i(wdata_i), .clr_wr_i(clr_wr),
    .count_o(count), .irq_o(irq_o)
  );

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (clr_wr && !(ctrl.run && (ctrl.fast ? tick_fast_i : tick_slow_i) && count == DATA_W'(1)))
    |=> !irq_o); // R7
endmodule

// File: tb/ctmr_top_bench.sv
module ctmr_top_bench;
  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_slow = 1'b0, tick_fast = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;
  int            n_chk = 0, n_bad = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  ctmr_top #(.DATA_W(DW), .ADDR_W(AW)) u_ctmr_top (
    .clk(clk), .rst_n(rst_n), .tick_slow_i(tick_slow), .tick_fast_i(tick_fast),
    .wr_en_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic tick(input bit fast);
    if (fast) tick_fast = 1'b1; else tick_slow = 1'b1;
    @(negedge clk);
    tick_fast = 1'b0; tick_slow = 1'b0;
  endtask

  task automatic chk_reg(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    logic [DW-1:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset();
    chk_reg("R1 reload", 4'h0, 0);
    chk_reg("R1 count", 4'h4, 0);
    chk_reg("R1 ctrl", 4'h8, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_readback();
    wr(4'h8, 32'hFFFF_FFF4);
    chk_reg("R9 ctrl mask", 4'h8, 32'h0);
    wr(4'h8, 32'hFFFF_FFFF);
    chk_reg("R9 ctrl bits", 4'h8, 32'hB);
    chk_reg("R9 clear reads zero", 4'hC, 32'h0);
    wr(4'h8, 32'h0);
  endtask

  task automatic t_stopped();
    wr(4'h0, 32'd50);
    chk_reg("R2 count set", 4'h4, 32'd50);
    tick(0); tick(1);
    chk_reg("R3 no count when stopped", 4'h4, 32'd50);
  endtask

  task automatic t_select();
    wr(4'h8, 32'h1);             // run, slow
    tick(1);
    chk_reg("R4 fast ignored", 4'h4, 32'd50);
    tick(0);
    chk_reg("R4 slow counts", 4'h4, 32'd49);
    wr(4'h8, 32'h9);             // run, fast
    tick(0);
    chk_reg("R4 slow ignored", 4'h4, 32'd49);
    tick(1);
    chk_reg("R4 fast counts", 4'h4, 32'd48);
    wr(4'h0, 32'h1234_5678);     // while running
    chk_reg("R2 load while running", 4'h4, 32'h1234_5678);
    chk_reg("R2 reload reads", 4'h0, 32'h1234_5678);
    wr(4'h8, 32'h0);
  endtask

  task automatic t_oneshot();
    wr(4'h0, 32'd3);
    wr(4'h8, 32'h1);
    tick(0); tick(0);
    check("R6 no irq early", {31'b0, irq}, 0);
    tick(0);
    check("R6 irq on expiry", {31'b0, irq}, 1);
    chk_reg("R6 count zero", 4'h4, 0);
    tick(0); tick(0);
    chk_reg("R5 holds zero", 4'h4, 0);
    @(negedge clk); @(negedge clk);
    wr(4'h8, 32'h0);
    check("R7 irq sticky", {31'b0, irq}, 1);
    wr(4'hC, 32'h0);
    check("R7 clear drops irq", {31'b0, irq}, 0);
  endtask

  task automatic t_repeat();
    wr(4'h0, 32'd2);
    wr(4'h8, 32'h3);
    tick(0);
    chk_reg("R8 count 1", 4'h4, 32'd1);
    tick(0);
    check("R8 first expiry", {31'b0, irq}, 1);
    wr(4'hC, 32'hDEAD_BEEF);
    tick(0);
    chk_reg("R8 reloaded", 4'h4, 32'd2);
    check("R8 irq cleared", {31'b0, irq}, 0);
    tick(0); tick(0);
    check("R8 second expiry", {31'b0, irq}, 1);
    wr(4'h8, 32'h0);
    wr(4'hC, 32'h0);
  endtask

  task automatic t_collide();
    wr(4'h0, 32'd1);
    wr(4'h8, 32'h1);
    // expiry and clear on the same edge
    we = 1'b1; addr = 4'hC; wdata = 32'h5; tick_slow = 1'b1;
    @(negedge clk);
    we = 1'b0; tick_slow = 1'b0;
    check("R10 expiry beats clear", {31'b0, irq}, 1);
    wr(4'hC, 32'h0);
    check("R10 later clear", {31'b0, irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_readback();
    t_stopped();
    t_select();
    t_oneshot();
    t_repeat();
    t_collide();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule